// File: doc/BRIEF.md
# Press-Order Combination Lock

This block opens a push-button lock only when the keys were pressed in a chosen order. Ten active-low key lines come in. Each new press makes a single common step pulse, whichever key caused it. Eight of the keys are tracked. Each tracked key owns an eight-position history shifter. On every step, the shifter of a key that is down takes in a 1, and every other tracked shifter takes in a 0. So after a run of presses, bit j of key k's shifter is 1 exactly when key k was pressed j steps before the latest one.

A configuration vector picks, for each tracked key, the history positions where that key must appear. The lock opens when every picked position holds a 1 in the same step. A key can be picked at several positions, so it may repeat in the combination. A key with nothing picked, and the two untracked keys, can only serve as filler that pushes the history along. The unlock output is registered. It is updated on each step and holds its value between steps.

Top module: `seq_lock_top`

## Requirements
- R1: Key inputs are active low: a key counts as pressed while its line is 0. Each line passes through two synchronizing flops, so a press that is stable before rising edge n affects `unlock` at rising edge n+2.
- R2: A step happens once per new press, on the first cycle in which some key is seen down after a cycle with no key down. This includes keys 8 and 9, which have no history. Holding a key, or pressing another key while one is still held, gives no further step.
- R3: On a step, bit 0 of each tracked key's history becomes 1 if that key is down in that cycle, and 0 otherwise.
- R4: On a step, bit j (1 to 7) of each history takes the old bit j-1. `tap_mask` bit k*8+j selects "key k was pressed j steps before the latest press", and j=0 is the latest press.
- R5: On each step, `unlock` is loaded with 1 if every selected history bit is 1 after that step, and with 0 otherwise. `unlock` keeps that value until the next step.
- R6: Several bits may be set in one key's mask, so one key can fill several positions of the combination.
- R7: A press older than 8 steps is lost, and a further press turns a completed combination back to locked. Keys with an all-zero mask still advance every history.
- R8: If several keys are first seen down in the same cycle, one step takes place and each of those keys shifts in a 1.
- R9: A synchronous active-low reset clears every history and `unlock` to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| key_n | input | 10 | Key lines, active low, asynchronous to clk |
| tap_mask | input | 64 | Bit k*8+j selects position j of key k |
| unlock | output | 1 | High while the last step completed the combination |

## Verification
The assertions assume that `tap_mask` is held steady across each step and the cycle after it. The check that ties `unlock` to the stored history is skipped when the mask moves during that window. Key lines may change at any time, because they are synchronized before any check sees them. The bench changes the mask only while reset is held or while all keys have been up for several cycles. It holds each press for several cycles and leaves gaps between presses, so every intended press makes exactly one step.

// File: rtl/seq_lock_pkg.sv
// Shared defaults for the press-order lock.
// Assumes NUM_KEYS >= NUM_TRACKED and HIST_DEPTH >= 2.
package seq_lock_pkg;
    localparam int unsigned KEYS_DEFAULT    = 10;
    localparam int unsigned TRACKED_DEFAULT = 8;
    localparam int unsigned DEPTH_DEFAULT   = 8;
endpackage

// File: rtl/seq_lock_sync.sv
// Two-flop synchronizer for the active-low key lines.
// Produces an active-high "pressed" vector. Assumes keys are debounced upstream.
module seq_lock_sync #(
    parameter int unsigned W = seq_lock_pkg::KEYS_DEFAULT
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] key_n,
    output logic [W-1:0] pressed
);
    logic [W-1:0] meta_n;
    logic [W-1:0] stable_n;

    // Two-stage capture; reset value means "no key down".
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            meta_n   <= '1;
            stable_n <= '1;
        end else begin
            meta_n   <= key_n;
            stable_n <= meta_n;
        end
    end

    assign pressed = ~stable_n;
endmodule

// File: rtl/seq_lock_strobe.sv
// Makes the single-cycle step pulse on the first cycle any key is down.
// Assumes the input is already synchronized to clk.
module seq_lock_strobe #(
    parameter int unsigned W = seq_lock_pkg::KEYS_DEFAULT
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] pressed,
    output logic         strobe
);
    logic any_down;
    logic any_down_q;

    // Any-key condition over every line, tracked or not.
    assign any_down = |pressed;

    // Remember the previous any-key state to find the new-press edge.
    always_ff @(posedge clk) begin
        if (!rst_n) any_down_q <= 1'b0;
        else        any_down_q <= any_down;
    end

    assign strobe = any_down & ~any_down_q;
endmodule

// File: rtl/seq_lock_history.sv
// Per-key serial-in/parallel-out history shifters, all stepped by one strobe.
// Bit 0 of each shifter is the newest step. Assumes DEPTH >= 2.
module seq_lock_history #(
    parameter int unsigned TRACKED = seq_lock_pkg::TRACKED_DEFAULT,
    parameter int unsigned DEPTH   = seq_lock_pkg::DEPTH_DEFAULT,
    localparam int unsigned BITS   = TRACKED * DEPTH
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               strobe,
    input  logic [TRACKED-1:0] key_in,
    output logic [BITS-1:0]    hist,
    output logic [BITS-1:0]    hist_next
);
    for (genvar k = 0; k < TRACKED; k++) begin : g_key
        logic [DEPTH-1:0] sr;
        logic [DEPTH-1:0] sr_next;

        // Shifted value: the key's own pressed bit enters at position 0.
        assign sr_next = {sr[DEPTH-2:0], key_in[k]};

        // Advance only on a step; clear on reset.
        always_ff @(posedge clk) begin
            if (!rst_n)      sr <= '0;
            else if (strobe) sr <= sr_next;
        end

        assign hist[k*DEPTH +: DEPTH]      = sr;
        assign hist_next[k*DEPTH +: DEPTH] = sr_next;
    end
endmodule

// File: rtl/seq_lock_match.sv
// Evaluates all selected taps on each step and holds the result as unlock.
// Assumes tap_mask is stable around each step.
module seq_lock_match #(
    parameter int unsigned BITS = seq_lock_pkg::TRACKED_DEFAULT * seq_lock_pkg::DEPTH_DEFAULT
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            strobe,
    input  logic [BITS-1:0] hist_next,
    input  logic [BITS-1:0] tap_mask,
    output logic            unlock
);
    logic all_met;

    // Every unselected tap passes; every selected tap must hold a 1.
    assign all_met = &(hist_next | ~tap_mask);

    // Load the verdict on each step, hold it otherwise.
    always_ff @(posedge clk) begin
        if (!rst_n)      unlock <= 1'b0;
        else if (strobe) unlock <= all_met;
    end
endmodule

// File: rtl/seq_lock_top.sv
// Press-order combination lock: synchronizer, step pulse, histories, tap match.
// Keys at or above TRACKED only make steps. Assumes NUM_KEYS >= TRACKED.
module seq_lock_top #(
    parameter int unsigned NUM_KEYS = seq_lock_pkg::KEYS_DEFAULT,
    parameter int unsigned TRACKED  = seq_lock_pkg::TRACKED_DEFAULT,
    parameter int unsigned DEPTH    = seq_lock_pkg::DEPTH_DEFAULT,
    localparam int unsigned BITS    = TRACKED * DEPTH
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [NUM_KEYS-1:0] key_n,
    input  logic [BITS-1:0]     tap_mask,
    output logic                unlock
);
    logic [NUM_KEYS-1:0] pressed;
    logic                strobe;
    logic [BITS-1:0]     hist;
    logic [BITS-1:0]     hist_next;

    seq_lock_sync #(.W(NUM_KEYS)) u_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .key_n   (key_n),
        .pressed (pressed)
    );

    seq_lock_strobe #(.W(NUM_KEYS)) u_strobe (
        .clk     (clk),
        .rst_n   (rst_n),
        .pressed (pressed),
        .strobe  (strobe)
    );

    seq_lock_history #(.TRACKED(TRACKED), .DEPTH(DEPTH)) u_hist (
        .clk       (clk),
        .rst_n     (rst_n),
        .strobe    (strobe),
        .key_in    (pressed[TRACKED-1:0]),
        .hist      (hist),
        .hist_next (hist_next)
    );

    seq_lock_match #(.BITS(BITS)) u_match (
        .clk       (clk),
        .rst_n     (rst_n),
        .strobe    (strobe),
        .hist_next (hist_next),
        .tap_mask  (tap_mask),
        .unlock    (unlock)
    );
endmodule

// File: rtl/seq_lock_chk.sv
// Property checker for seq_lock_top, attached by bind.
// Assumes tap_mask is stable across a step for the match property.
module seq_lock_chk #(
    parameter int unsigned NUM_KEYS = 10,
    parameter int unsigned TRACKED  = 8,
    parameter int unsigned DEPTH    = 8,
    localparam int unsigned BITS    = TRACKED * DEPTH
) (
    input logic                clk,
    input logic                rst_n,
    input logic [NUM_KEYS-1:0] pressed,
    input logic                strobe,
    input logic [BITS-1:0]     hist,
    input logic [BITS-1:0]     tap_mask,
    input logic                unlock
);
    logic [TRACKED-1:0] newest;
    logic [BITS-1:0]    shifted;
    logic [BITS-1:0]    upper_sel;

    // Gather newest bits and the expected shifted image of the histories.
    always_comb begin
        for (int k = 0; k < TRACKED; k++) begin
            newest[k] = hist[k*DEPTH];
            for (int j = 0; j < DEPTH; j++) begin
                shifted[k*DEPTH+j]   = (j == 0) ? 1'b0 : hist[k*DEPTH+j-1];
                upper_sel[k*DEPTH+j] = (j != 0);
            end
        end
    end

    // R9
    reset_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $past(!rst_n) |-> (!unlock && hist == '0));

    // R2
    single_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        strobe |=> !strobe);

    // R3
    newest_bit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        strobe |=> newest == $past(pressed[TRACKED-1:0]));

    // R4
    shift_chk: assert property (@(posedge clk) disable iff (!rst_n)
        strobe |=> (hist & upper_sel) == $past(shifted));

    // R5
    hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !strobe |=> ($stable(unlock) && $stable(hist)));

    // R5
    match_chk: assert property (@(posedge clk) disable iff (!rst_n)
        strobe |=> (tap_mask != $past(tap_mask)) || (unlock == &(hist | ~tap_mask)));
endmodule

bind seq_lock_top seq_lock_chk #(
    .NUM_KEYS (NUM_KEYS),
    .TRACKED  (TRACKED),
    .DEPTH    (DEPTH)
) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .pressed  (pressed),
    .strobe   (strobe),
    .hist     (hist),
    .tap_mask (tap_mask),
    .unlock   (unlock)
);

// File: tb/tb_seq_lock_top.sv
module tb_seq_lock_top;
    localparam int NK = 10;
    localparam int NT = 8;
    localparam int D  = 8;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [NK-1:0] key_n = '1;
    logic [NT*D-1:0] tap_mask = '0;
    logic          unlock;

    int checks = 0;
    int errors = 0;

    always #4 clk = ~clk;

    seq_lock_top dut (
        .clk      (clk),
        .rst_n    (rst_n),
        .key_n    (key_n),
        .tap_mask (tap_mask),
        .unlock   (unlock)
    );

    task automatic check(input string req, input logic got, input logic exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s unlock=%0b expected=%0b", req, got, exp);
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        key_n = '1;
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
    endtask

    // Press a set of keys (bit i = key i), hold, release, settle.
    task automatic press(input logic [NK-1:0] keys, input int hold);
        @(negedge clk);
        key_n = ~keys;
        repeat (hold) @(negedge clk);
        key_n = '1;
        repeat (4) @(negedge clk);
    endtask

    function automatic logic [NT*D-1:0] tap(input int k, input int j);
        logic [NT*D-1:0] m = '0;
        m[k*D+j] = 1'b1;
        return m;
    endfunction

    initial begin
        int seq[D];
        int n;
        // R9: reset state with an empty and a non-empty mask
        do_reset();
        check("R9 empty mask after reset", unlock, 1'b0);
        tap_mask = tap(3, 0);
        @(negedge clk);
        check("R9 mask set after reset", unlock, 1'b0);

        // R1 timing: unlock appears two edges after the sampled press
        do_reset();
        tap_mask = tap(3, 0);
        @(negedge clk);
        key_n = ~(10'b1 << 3);
        @(negedge clk);
        @(negedge clk);
        check("R1 not yet after two edges", unlock, 1'b0);
        @(negedge clk);
        check("R1 after three edges", unlock, 1'b1);
        key_n = '1;
        repeat (4) @(negedge clk);

        // R3 R4 R5 R2: sweep every single tap against press streams incl. keys 8,9
        for (int k = 0; k < NT; k++) begin
            for (int j = 0; j < D; j++) begin
                do_reset();
                tap_mask = tap(k, j);
                for (int i = 0; i < D; i++) begin
                    seq[i] = (i * 7 + k + 3 * j) % NK;
                    press(10'b1 << seq[i], 3);
                    n = i + 1;
                    check("R4 single-tap sweep", unlock,
                          (n > j) && (seq[n-1-j] == k));
                end
            end
        end

        // R6 R5 R7: full combination with a repeated key and an untracked filler
        // oldest..newest: 2,5,1,9,5,7,0,4
        do_reset();
        tap_mask = tap(2, 7) | tap(5, 6) | tap(1, 5) | tap(5, 3)
                 | tap(7, 2) | tap(0, 1) | tap(4, 0);
        press(10'b1 << 2, 3); press(10'b1 << 5, 3); press(10'b1 << 1, 3);
        press(10'b1 << 9, 3); press(10'b1 << 5, 3); press(10'b1 << 7, 3);
        press(10'b1 << 0, 3);
        check("R5 one short", unlock, 1'b0);
        press(10'b1 << 4, 3);
        check("R6 repeated key combination", unlock, 1'b1);
        repeat (30) @(negedge clk);
        check("R5 holds between steps", unlock, 1'b1);
        press(10'b1 << 6, 3);
        check("R7 extra press relocks", unlock, 1'b0);

        // R6: repeated key in wrong slot order (5 swapped with 1)
        do_reset();
        press(10'b1 << 2, 3); press(10'b1 << 1, 3); press(10'b1 << 5, 3);
        press(10'b1 << 8, 3); press(10'b1 << 5, 3); press(10'b1 << 7, 3);
        press(10'b1 << 0, 3); press(10'b1 << 4, 3);
        check("R6 wrong order stays locked", unlock, 1'b0);

        // R2: held key makes one step only
        do_reset();
        tap_mask = tap(0, 2);
        press(10'b1 << 0, 20);
        press(10'b1 << 3, 3);
        check("R2 long hold gives one step", unlock, 1'b0);
        do_reset();
        tap_mask = tap(0, 1) | tap(3, 0);
        press(10'b1 << 0, 20);
        press(10'b1 << 3, 3);
        check("R2 held key counted once", unlock, 1'b1);

        // R2: second key pressed while first still held is no step
        do_reset();
        tap_mask = tap(2, 0);
        @(negedge clk);
        key_n = ~(10'b1 << 1);
        repeat (4) @(negedge clk);
        key_n = ~((10'b1 << 1) | (10'b1 << 2));
        repeat (4) @(negedge clk);
        key_n = '1;
        repeat (4) @(negedge clk);
        check("R2 overlapped press ignored", unlock, 1'b0);

        // R8: simultaneous press shifts a 1 into each key
        do_reset();
        tap_mask = tap(1, 0) | tap(2, 0);
        press((10'b1 << 1) | (10'b1 << 2), 3);
        check("R8 simultaneous keys", unlock, 1'b1);

        // R7: untracked-only presses age history out
        do_reset();
        tap_mask = tap(6, 7);
        press(10'b1 << 6, 3);
        for (int i = 0; i < D - 1; i++) press(10'b1 << 9, 3);
        check("R7 oldest slot reached", unlock, 1'b1);
        press(10'b1 << 8, 3);
        check("R7 oldest press dropped", unlock, 1'b0);

        // R9: reset clears stored history
        do_reset();
        tap_mask = tap(0, 0);
        press(10'b1 << 0, 3);
        check("R9 pre-reset unlocked", unlock, 1'b1);
        do_reset();
        check("R9 reset clears unlock", unlock, 1'b0);
        tap_mask = tap(0, 1);
        press(10'b1 << 5, 3);
        check("R9 history cleared", unlock, 1'b0);

        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog expired");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule